// File: doc/BRIEF.md
# Vector Sign-Fill Unit

This block turns every element of a 128-bit vector into an all-ones or all-zeros mask, chosen by that element's top bit. The element size is picked per operation from five choices: 8, 16, 32, 64 or 128 bits. The effect equals an arithmetic right shift of each element by its width minus one. A compare result held as sign bits can then be used directly as a lane mask.

The unit decodes a 32-bit instruction word itself. It raises a decode-valid flag only when the word encodes this operation with a supported size. It also breaks out the destination and source register indices for the surrounding register-file logic. With the `REG_OUT` parameter set, which is the default, the mask result is registered. It appears one clock after a valid strobe and stays unchanged until the next accepted operation.

Top module: `vec_sign_fill_unit`

## Requirements
- R1: Every element of the selected size becomes all ones when its most significant bit is 1, and all zeros when that bit is 0.
- R2: Size selector value 5'b00000 in instruction bits 20:16 selects 8-bit elements (16 lanes).
- R3: Selector values 5'b00001, 5'b00010 and 5'b00011 select 16-bit, 32-bit and 64-bit elements respectively.
- R4: Selector value 5'b00100 selects one 128-bit element, so source bit 127 fills all 128 result bits.
- R5: `dec_valid` is high only when `in_valid` is high, instruction bits 31:26 equal 6'b000100, and bits 10:0 equal 11'b11001000010.
- R6: Selector values 5'b00101 through 5'b11111 hold `dec_valid` low and leave `result` unchanged.
- R7: `dst_idx` always equals instruction bits 25:21 and `src_idx` always equals bits 15:11.
- R8: With a registered output, `result` and `out_valid` update one clock after a cycle with `dec_valid` high. A cycle without `dec_valid` clears `out_valid` and holds `result`.
- R9: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0, even when a valid operation is presented at the same time.
- R10: Elements are independent: an element's top bit affects only the bits of that element, never a neighbouring element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking `instr` and `src_vec` as meaningful |
| instr | input | 32 | Instruction word to decode |
| src_vec | input | 128 | Source vector operand |
| dec_valid | output | 1 | Combinational: the word is this operation with a supported size |
| dst_idx | output | 5 | Destination vector register index |
| src_idx | output | 5 | Source vector register index |
| result | output | 128 | Sign-filled mask vector |
| out_valid | output | 1 | `result` was updated by the previous cycle's operation |

## Verification
The assertions assume `instr` and `src_vec` are stable whenever `in_valid` is sampled. They also assume `rst` is held high from the first clock edge, so that the registered result begins at a known zero. The bench drives every input on the falling edge and holds it through the following rising edge. It starts the run with reset asserted for several cycles. It also pulses reset only while the inputs are stable, so every property sees settled inputs.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

    localparam int          NUM_SIZES  = 5;
    localparam int          BASE_EW    = 8;
    localparam logic [5:0]  PRIMARY_OP = 6'b000100;
    localparam logic [10:0] EXT_OP     = 11'b11001000010;

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_DWORD = 3'd3,
        SZ_QUAD  = 3'd4
    } elem_size_e;

    typedef struct packed {
        logic       ok;
        elem_size_e size;
        logic [4:0] dst;
        logic [4:0] src;
    } dec_info_t;

    function automatic int elem_width(input int k);
        return BASE_EW << k;
    endfunction

endpackage

// File: rtl/vsf_decode.sv
module vsf_decode
    import vsf_pkg::*;
(
    input  logic        in_valid,
    input  logic [31:0] instr,
    output dec_info_t   info
);

    logic [5:0]  prim_field;
    logic [10:0] ext_field;
    logic [4:0]  size_field;
    logic        size_legal;

    always_comb begin
        prim_field = instr[31:26];
        ext_field  = instr[10:0];
        size_field = instr[20:16];
        size_legal = (size_field < 5'(NUM_SIZES));

        info      = '0;
        info.dst  = instr[25:21];
        info.src  = instr[15:11];
        info.ok   = in_valid && (prim_field == PRIMARY_OP)
                    && (ext_field == EXT_OP) && size_legal;
        info.size = size_legal ? elem_size_e'(size_field[2:0]) : SZ_BYTE;
    end

endmodule

// File: rtl/vsf_fill.sv
module vsf_fill
    import vsf_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] src_vec,
    input  elem_size_e       size_sel,
    output logic [VEC_W-1:0] fill_vec
);

    logic [VEC_W-1:0] cand [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int EW = elem_width(k);
        localparam int NE = (EW <= VEC_W) ? (VEC_W / EW) : 0;
        if (NE == 0) begin : g_none
            assign cand[k] = '0;
        end else begin : g_lanes
            for (genvar e = 0; e < NE; e++) begin : g_lane
                assign cand[k][e*EW +: EW] = {EW{src_vec[e*EW + EW - 1]}};
            end
        end
    end

    always_comb begin
        fill_vec = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (size_sel == elem_size_e'(k)) begin
                fill_vec = cand[k];
            end
        end
    end

endmodule

// File: rtl/vsf_out_stage.sv
module vsf_out_stage #(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [VEC_W-1:0] fill_vec,
    output logic [VEC_W-1:0] result,
    output logic             out_valid
);

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = dec_valid;
        if (dec_valid) begin
            st_d.res = fill_vec;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign result    = st_q.res;
    assign out_valid = st_q.vld;

    AST_LATENCY_VALID: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> out_valid); // R8
    AST_IDLE_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> !out_valid); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> $stable(result)); // R6

endmodule

// File: rtl/vec_sign_fill_unit.sv
module vec_sign_fill_unit
    import vsf_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] src_vec,
    output logic             dec_valid,
    output logic [4:0]       dst_idx,
    output logic [4:0]       src_idx,
    output logic [VEC_W-1:0] result,
    output logic             out_valid
);

    dec_info_t        info;
    logic [VEC_W-1:0] fill_vec;

    vsf_decode u_decode (
        .in_valid (in_valid),
        .instr    (instr),
        .info     (info)
    );

    vsf_fill #(.VEC_W(VEC_W)) u_fill (
        .src_vec  (src_vec),
        .size_sel (info.size),
        .fill_vec (fill_vec)
    );

    assign dec_valid = info.ok;
    assign dst_idx   = info.dst;
    assign src_idx   = info.src;

    if (REG_OUT) begin : g_reg
        vsf_out_stage #(.VEC_W(VEC_W)) u_out (
            .clk       (clk),
            .rst       (rst),
            .dec_valid (info.ok),
            .fill_vec  (fill_vec),
            .result    (result),
            .out_valid (out_valid)
        );

        AST_QUAD_FILL: assert property (@(posedge clk) disable iff (rst)
            (dec_valid && instr[20:16] == 5'd4) |=>
            (((result == '0) || (&result)) && (result[0] == $past(src_vec[VEC_W-1])))); // R4
    end else begin : g_comb
        assign result    = info.ok ? fill_vec : '0;
        assign out_valid = info.ok;
    end

    AST_OPCODE_MATCH: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (in_valid && instr[31:26] == 6'b000100
                       && instr[10:0] == 11'b11001000010)); // R5
    AST_BAD_SIZE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (instr[20:16] > 5'd4) |-> !dec_valid); // R6

endmodule

// File: tb/vec_sign_fill_unit_bench.sv
`timescale 1ns/1ps
module vec_sign_fill_unit_bench;

    localparam int W = 128;
    localparam int NT = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   instr = '0;
    logic [W-1:0]  src_vec = '0;
    logic          dec_valid;
    logic [4:0]    dst_idx, src_idx;
    logic [W-1:0]  result;
    logic          out_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vec_sign_fill_unit u_vec_sign_fill_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_vec(src_vec), .dec_valid(dec_valid), .dst_idx(dst_idx),
        .src_idx(src_idx), .result(result), .out_valid(out_valid)
    );

    localparam logic [4:0] TV_SIZE [NT] = '{
        5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd4, 5'd0, 5'd1, 5'd2
    };
    localparam logic [W-1:0] TV_SRC [NT] = '{
        128'h80000000_00000000_00000000_000000FF,
        128'h8000_7FFF_0000_FFFF_0001_8001_7000_C000,
        128'h80000000_7FFFFFFF_FFFFFFFF_00000001,
        128'h7FFFFFFF_FFFFFFFF_80000000_00000000,
        128'h80000000_00000000_00000000_00000000,
        128'h7FFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h807F807F_807F807F_807F807F_807F807F,
        128'h807F807F_807F807F_807F807F_807F807F,
        128'h00008000_00008000_80000000_00800000
    };
    localparam logic [W-1:0] TV_EXP [NT] = '{
        128'hFF000000_00000000_00000000_000000FF,
        128'hFFFF_0000_0000_FFFF_0000_FFFF_0000_FFFF,
        128'hFFFFFFFF_00000000_FFFFFFFF_00000000,
        128'h00000000_00000000_FFFFFFFF_FFFFFFFF,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h00000000_00000000_00000000_00000000,
        128'hFF00FF00_FF00FF00_FF00FF00_FF00FF00,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h00000000_00000000_FFFFFFFF_00000000
    };

    function automatic string tv_req(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2: return "R3";
            3: return "R3";
            4: return "R4";
            5: return "R4";
            6: return "R10";
            7: return "R1";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] mk_instr(input logic [4:0] sz, input logic [4:0] d,
                                             input logic [4:0] s);
        return {6'b000100, d, sz, s, 11'b11001000010};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one operation on a falling edge, check decode, then the registered result.
    task automatic run_op(input string req, input logic [31:0] word, input logic [W-1:0] s,
                          input logic exp_dec, input logic [W-1:0] exp_res);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = word;
        src_vec  = s;
        #1;
        check(req, "dec_valid", W'(dec_valid), W'(exp_dec));
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "result", result, exp_res);
        check(req, "out_valid", W'(out_valid), W'(exp_dec));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        check("R9", "reset result", result, '0);
        check("R9", "reset out_valid", W'(out_valid), '0);

        for (int i = 0; i < NT; i++) begin
            run_op(tv_req(i), mk_instr(TV_SIZE[i], 5'd3, 5'd7), TV_SRC[i], 1'b1, TV_EXP[i]);
        end

        // R7 index extraction
        @(negedge clk);
        instr = mk_instr(5'd2, 5'd21, 5'd10);
        #1;
        check("R7", "dst_idx", W'(dst_idx), W'(5'd21));
        check("R7", "src_idx", W'(src_idx), W'(5'd10));
        instr = {6'b111111, 5'd9, 5'd31, 5'd30, 11'h7FF};
        #1;
        check("R7", "dst_idx bad word", W'(dst_idx), W'(5'd9));
        check("R7", "src_idx bad word", W'(src_idx), W'(5'd30));

        held = 128'hFF00FF00_FF00FF00_FF00FF00_FF00FF00;
        run_op("R1", mk_instr(5'd0, 5'd1, 5'd2), 128'h80008000_80008000_80008000_80008000, 1'b1, held);
        // R5 wrong primary opcode, wrong extended opcode
        run_op("R5", {6'b000101, 5'd1, 5'd0, 5'd2, 11'b11001000010}, '1, 1'b0, held);
        run_op("R5", {6'b000100, 5'd1, 5'd0, 5'd2, 11'b11001000011}, '1, 1'b0, held);
        // R6 unsupported selectors
        run_op("R6", mk_instr(5'd5, 5'd1, 5'd2), '1, 1'b0, held);
        run_op("R6", mk_instr(5'd31, 5'd1, 5'd2), '1, 1'b0, held);
        run_op("R6", mk_instr(5'd8, 5'd1, 5'd2), '1, 1'b0, held);

        // R8 no strobe: hold result, no out_valid
        @(negedge clk);
        in_valid = 1'b0;
        instr    = mk_instr(5'd4, 5'd1, 5'd2);
        src_vec  = '1;
        #1;
        check("R8", "dec_valid without strobe", W'(dec_valid), '0);
        @(negedge clk);
        check("R8", "result held", result, held);
        check("R8", "out_valid idle", W'(out_valid), '0);

        // R9 reset overrides a valid operation
        @(negedge clk);
        in_valid = 1'b1;
        rst      = 1'b1;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        check("R9", "reset with valid op result", result, '0);
        check("R9", "reset with valid op out_valid", W'(out_valid), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule